// File: doc/BRIEF.md
# NAND Ready-Line Event Detector

This block watches the ready/busy (interrupt) line coming from a NAND-type memory. It records three kinds of event on that line: a rising edge, a falling edge and a high level. Each event has its own enable bit and its own sticky status flag. The raw line is asynchronous to the system clock, so it first passes through a flop synchroniser. Edges are then found by comparing each synchronised sample with the one taken on the previous cycle.

Software reaches the block through one word-wide register. The register port is single-cycle: a write takes effect at the next clock edge, and the read data is always valid. The register holds the three enables, the three status flags and a read-only copy of an external FIFO-empty indication. The interrupt request output is high whenever an enabled event has its flag set.

Top module: `nand_irq_detect`

## Requirements
- R1: The register bits are: 0 = rising-edge flag, 1 = high-level flag, 2 = falling-edge flag, 3 = rising-edge enable, 4 = high-level enable, 5 = falling-edge enable, 6 = FIFO-empty status. The three flags use the same order as the three enables.
- R2: Register bits above bit 6 always read 0, and writing them has no effect.
- R3: Bit 6 reads 1 exactly when `fifo_empty` is 1. Writes to bit 6 have no effect.
- R4: A 0-to-1 change on `rdy_in` sets bit 0 when bit 3 is 1. Count the clock edges from the first rising clock edge that samples the new level of `rdy_in`: the flag is visible on `rdata` after the third of those edges.
- R5: A 1-to-0 change on `rdy_in` sets bit 2 when bit 5 is 1. The timing is the same as in R4.
- R6: The high-level flag (bit 1) is set on every cycle in which the synchronised input is 1 and bit 4 is 1. Writing 1 to bit 1 has no effect. Writing 0 to bit 1 clears it.
- R7: No status flag is set by hardware while its enable bit is 0.
- R8: Every status flag stays set until software writes 0 to it. Writing 1 to bit 0 or to bit 2 sets that flag, whatever its enable.
- R9: If hardware sets a flag in the same cycle that software writes 0 to it, the flag ends up set.
- R10: `irq_o` equals the OR, taken over the three event kinds, of (enable AND flag).
- R11: Reset clears all enables and all flags. If `rdy_in` is held high through reset, no edge is recorded after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rdy_in | input | 1 | Asynchronous ready/interrupt line from the memory |
| fifo_empty | input | 1 | FIFO-empty indication, shown on bit 6 |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Flag and enable state can be read straight back on `rdata`. A wrong internal state therefore shows at the ports at the latest one clock after the bad update. A mis-sized synchroniser or a broken previous-sample register shows up as an edge flag that appears one cycle early or late, or that never appears. The bench checks R4 cycle by cycle for this reason. A wrong set/clear priority shows up as a high-level flag that reads 0 just after a clearing write while the line is still high. A wrong interrupt combine shows up as `irq_o` disagreeing with the enable and flag bits on the same read. The bench sweeps all eight enable combinations to expose this.

// File: rtl/irqdet_pkg.sv
package irqdet_pkg;
  localparam int unsigned NUM_EVT  = 3;
  localparam int unsigned EVT_RISE = 0;
  localparam int unsigned EVT_LVL  = 1;
  localparam int unsigned EVT_FALL = 2;
  localparam int unsigned EN_LSB   = NUM_EVT;
  localparam int unsigned FIFO_BIT = 2 * NUM_EVT;
  localparam int unsigned USED_W   = FIFO_BIT + 1;
  // flags that a software write of 1 may set
  localparam logic [NUM_EVT-1:0] SW_SET_MASK = 3'b101;

  function automatic logic irq_of(input logic [NUM_EVT-1:0] en,
                                  input logic [NUM_EVT-1:0] st);
    return |(en & st);
  endfunction

  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic wr, input logic wbit,
                                     input logic sw_can_set);
    logic keep;
    keep = wr ? (wbit & (sw_can_set | cur)) : cur;
    return hw_set | keep;
  endfunction
endpackage

// File: rtl/irqdet_sync.sv
module irqdet_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  // Reset loads the current level, so the chain starts settled.
  always_ff @(posedge clk) begin
    if (!rst_n) stg <= {STAGES{d}};
    else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irqdet_edge.sv
module irqdet_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  output logic rise,
  output logic fall,
  output logic lvl
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= s;
    else        prev_q <= s;
  end

  assign rise = s & ~prev_q & rst_n;
  assign fall = ~s & prev_q & rst_n;
  assign lvl  = s & rst_n;
endmodule

// File: rtl/irqdet_flags.sv
module irqdet_flags
  import irqdet_pkg::*;
#(
  parameter int unsigned N = NUM_EVT,
  parameter logic [N-1:0] SW_SET = SW_SET_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] w_stat,
  input  logic [N-1:0] w_en,
  input  logic [N-1:0] evt,
  output logic [N-1:0] en_q,
  output logic [N-1:0] st_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= w_en;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic hw_set;
    assign hw_set = evt[i] & en_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= flag_next(st_q[i], hw_set, wr_en, w_stat[i], SW_SET[i]);
    end
  end
endmodule

// File: rtl/nand_irq_detect.sv
module nand_irq_detect
  import irqdet_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdy_in,
  input  logic              fifo_empty,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o
);
  logic               rdy_s;
  logic               rise_ev, fall_ev, lvl_ev;
  logic [NUM_EVT-1:0] evt_vec, en_q, st_q;

  irqdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
  );

  irqdet_edge u_edge (
    .clk(clk), .rst_n(rst_n), .s(rdy_s),
    .rise(rise_ev), .fall(fall_ev), .lvl(lvl_ev)
  );

  always_comb begin
    evt_vec           = '0;
    evt_vec[EVT_RISE] = rise_ev;
    evt_vec[EVT_LVL]  = lvl_ev;
    evt_vec[EVT_FALL] = fall_ev;
  end

  irqdet_flags #(.N(NUM_EVT), .SW_SET(SW_SET_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .w_stat(wdata[NUM_EVT-1:0]),
    .w_en(wdata[EN_LSB +: NUM_EVT]),
    .evt(evt_vec), .en_q(en_q), .st_q(st_q)
  );

  always_comb begin
    rdata                    = '0;
    rdata[NUM_EVT-1:0]       = st_q;
    rdata[EN_LSB +: NUM_EVT] = en_q;
    rdata[FIFO_BIT]          = fifo_empty;
  end

  assign irq_o = irq_of(en_q, st_q);
endmodule

// File: rtl/irqdet_chk.sv
module irqdet_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_empty,
  input logic              wr_en,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_o,
  input logic              rise_ev,
  input logic              fall_ev,
  input logic              lvl_ev
);
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:7] == '0);

  p_fifo_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6] == fifo_empty);

  p_rise_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && rdata[3]) |=> rdata[0]);

  p_fall_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && rdata[5]) |=> rdata[2]);

  p_lvl_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_ev && rdata[4]) |=> rdata[1]);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rdata[0]) |=> rdata[0]);

  p_sw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2]) |=> rdata[2]);

  p_no_set_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rdata[1] && !rdata[4]) |=> !rdata[1]);

  p_irq_combine_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(rdata[5:3] & rdata[2:0]));
endmodule

bind nand_irq_detect irqdet_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .lvl_ev(lvl_ev)
);

// File: tb/sim_nand_irq_detect.sv
`timescale 1ns/1ps
module sim_nand_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rdy_in = 1'b1;
  logic        fifo_empty = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always #5 clk = ~clk;

  nand_irq_detect u0 (
    .clk(clk), .rst_n(rst_n), .rdy_in(rdy_in), .fifo_empty(fifo_empty),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, act=%0d exp<=5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    wr_en = 1'b1;
    wdata = v;
    tick();
    wr_en = 1'b0;
    wdata = '0;
  endtask

  // Bench model of the read value: status in bits 2:0, enables in 5:3, FIFO in 6.
  function automatic logic [31:0] exp_rd(input logic [2:0] en, input logic [2:0] st,
                                         input logic fe);
    return {25'd0, fe, en, st};
  endfunction

  initial begin
    // R11: input held high through reset
    tick(3);
    rst_n = 1'b1;
    tick();
    chk("R11 reset value", rdata, exp_rd(3'b000, 3'b000, 1'b1));
    chk("R11 irq after reset", {31'd0, irq_o}, 32'd0);
    wr(32'h08);
    tick(4);
    chk("R11 no false edge", rdata, exp_rd(3'b001, 3'b000, 1'b1));

    // R2/R3: reserved bits and the FIFO bit ignore writes
    rdy_in = 1'b0;
    tick(4);
    wr(32'hFFFF_FFC0);
    tick();
    chk("R2 reserved", rdata, exp_rd(3'b000, 3'b000, 1'b1));
    fifo_empty = 1'b0;
    #1;
    chk("R3 fifo low", rdata, exp_rd(3'b000, 3'b000, 1'b0));
    wr(32'h40);
    chk("R3 fifo write ignored", rdata, exp_rd(3'b000, 3'b000, 1'b0));
    fifo_empty = 1'b1;

    // R7/R10/R1: sweep all enable combinations over one high pulse
    for (int m = 0; m < 8; m++) begin
      rdy_in = 1'b0;
      tick(4);
      wr({26'd0, 3'(m), 3'b000});
      rdy_in = 1'b1;
      tick(3);
      rdy_in = 1'b0;
      tick(5);
      chk("R7 sweep flags", rdata, exp_rd(3'(m), 3'(m), 1'b1));
      chk("R10 sweep irq", {31'd0, irq_o}, {31'd0, m != 0});
    end

    // R4: exact latency of the rising-edge flag
    wr(32'h08);
    tick(2);
    rdy_in = 1'b1;
    tick();
    chk("R4 edge1", {31'd0, rdata[0]}, 32'd0);
    tick();
    chk("R4 edge2", {31'd0, rdata[0]}, 32'd0);
    tick();
    chk("R4 edge3", {31'd0, rdata[0]}, 32'd1);

    // R5: exact latency of the falling-edge flag
    wr(32'h20);
    tick(2);
    rdy_in = 1'b0;
    tick(2);
    chk("R5 edge2", {31'd0, rdata[2]}, 32'd0);
    tick();
    chk("R5 edge3", {31'd0, rdata[2]}, 32'd1);

    // R9: clear races a hardware set while the line is high
    wr(32'h10);
    rdy_in = 1'b1;
    tick(4);
    wr(32'h10);
    chk("R9 hw wins", rdata, exp_rd(3'b010, 3'b010, 1'b1));
    rdy_in = 1'b0;
    tick(4);
    wr(32'h10);
    chk("R6 clear level", rdata, exp_rd(3'b010, 3'b000, 1'b1));
    wr(32'h12);
    chk("R6 write1 level no effect", rdata, exp_rd(3'b010, 3'b000, 1'b1));

    // R8: software set of edge flags, stickiness and clear
    wr(32'h05);
    chk("R8 sw set edges", rdata, exp_rd(3'b000, 3'b101, 1'b1));
    chk("R10 irq masked", {31'd0, irq_o}, 32'd0);
    wr(32'h2D);
    tick(3);
    chk("R8 sticky", rdata, exp_rd(3'b101, 3'b101, 1'b1));
    chk("R10 irq on", {31'd0, irq_o}, 32'd1);
    wr(32'h28);
    chk("R8 cleared", rdata, exp_rd(3'b101, 3'b000, 1'b1));
    chk("R10 irq off", {31'd0, irq_o}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule